// File: doc/BRIEF.md
# Endpoint DMA Burst Sequencer

This block paces DMA traffic on a 16-bit data bus for a single chosen endpoint buffer. Software programs a transfer length and a configuration word through a two-entry register port. It then sets the run bit. The block copies the programmed length into a live down-counter and raises a request whenever the endpoint can take or supply a whole burst. It keeps the request up until the burst's byte quota has been acknowledged, and takes two bytes off the counter for each acknowledged word. When only one byte is left, it takes off one.

A transfer ends in one of three ways. The counter runs out, which produces an end-of-transfer pulse if counter termination is enabled. A short or empty packet arrives on an OUT endpoint while short-packet mode is on. Or software clears the run bit. A USB bus reset stops DMA but leaves every other setting, the programmed length and the remaining count untouched. A status bit tells software whether the final data cycle moved a full word or only the low byte.

Top module: `dma_burst_ctl`

## Requirements
- R1: After `rst_n` is low, both register reads return 0, and `dreq` and `eot` are 0.
- R2: The configuration word has this layout: bit 0 run, bits 2:1 burst code, bits 6:3 endpoint index (also driven on `ep_index`), bit 7 counter-termination enable, bit 8 short-packet enable, bit 9 last-access-was-word (read-only; writes to it are ignored). `reg_sel`=0 selects the configuration word and `reg_sel`=1 selects the length register.
- R3: A write to the length register sets the programmed length. A read of it returns the bytes still remaining. Each 0-to-1 write of the run bit loads the remaining count from the programmed length.
- R4: Each cycle with `dreq` and `dack` both high takes 2 off the remaining count. When the remaining count is 1, it takes 1 off instead. Bit 9 is then set to 1 after a 2-byte cycle and to 0 after a 1-byte cycle.
- R5: The burst code sets the bytes per request: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 16. `dreq` drops in the cycle after the acknowledged bytes of the burst reach that quota or the count reaches zero.
- R6: A new burst request is raised only while the run bit is 1, the remaining count is non-zero and `ep_ready` is 1. Once a burst has started, it continues without `ep_ready`.
- R7: One cycle after the run bit is seen at 1 with a zero remaining count, the run bit clears. If counter termination is enabled, `eot` is high for exactly that one cycle; otherwise `eot` stays low.
- R8: A `short_pkt` pulse while running, with short-packet enable at 1 and `ep_is_out` at 1, clears the run bit and pulses `eot` in the next cycle. With either of those two bits at 0, the pulse has no effect.
- R9: Writing the run bit as 0 drops `dreq` in the next cycle without any `eot`.
- R10: A `bus_reset` cycle clears the run bit and any burst in progress. All other configuration fields, the programmed length and the remaining count keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_reset | input | 1 | USB bus reset, one cycle per event |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects configuration, 1 selects length |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| ep_ready | input | 1 | Endpoint can supply or accept a full burst |
| ep_is_out | input | 1 | Selected endpoint is an OUT endpoint |
| short_pkt | input | 1 | Short or empty packet received |
| dack | input | 1 | Data cycle acknowledge |
| dreq | output | 1 | DMA request |
| eot | output | 1 | End-of-transfer pulse |
| ep_index | output | 4 | Selected endpoint index |
| last_word | output | 1 | Last data cycle moved a full word |

## Verification
The hardest point to reach is a burst boundary that lands partway through a transfer. There the acknowledged bytes meet the quota while the counter is still non-zero, and in the last burst the quota must give way to a single odd byte. The bench raises `ep_ready` only for the first beat of each burst and holds `dack` high, so that only the burst logic can keep the request alive. It sweeps every burst code against every length from 0 to 19, with and without counter termination. This places every boundary position and both final access sizes under check.

// File: rtl/dma_burst_ctl.sv
module dma_burst_ctl #(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_reset,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ep_ready,
  input  logic        ep_is_out,
  input  logic        short_pkt,
  input  logic        dack,
  output logic        dreq,
  output logic        eot,
  output logic [3:0]  ep_index,
  output logic        last_word
);
  logic             en_q, ceot_q, shen_q, lastw_q, eot_q;
  logic [1:0]       burst_q;
  logic [3:0]       ep_q;
  logic [LEN_W-1:0] len_q, cnt_q, step;
  logic [4:0]       bcnt_q, quota, moved;
  logic             ack, done_cnt, short_hit;

  always_comb begin
    case (burst_q)
      2'd0:    quota = 5'd1;
      2'd1:    quota = 5'd4;
      2'd2:    quota = 5'd8;
      default: quota = 5'd16;
    endcase
  end

  assign step      = (cnt_q == LEN_W'(1)) ? LEN_W'(1) : LEN_W'(2);
  assign moved     = bcnt_q + 5'(step);
  assign dreq      = en_q && (cnt_q != '0) && (ep_ready || bcnt_q != '0);
  assign ack       = dreq && dack;
  assign done_cnt  = en_q && (cnt_q == '0);
  assign short_hit = en_q && shen_q && ep_is_out && short_pkt;

  assign eot       = eot_q;
  assign ep_index  = ep_q;
  assign last_word = lastw_q;
  assign reg_rdata = reg_sel ? 16'(cnt_q)
                             : {6'd0, lastw_q, shen_q, ceot_q, ep_q, burst_q, en_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ceot_q <= 1'b0; shen_q <= 1'b0; lastw_q <= 1'b0; eot_q <= 1'b0;
      burst_q <= '0; ep_q <= '0; len_q <= '0; cnt_q <= '0; bcnt_q <= '0;
    end else begin
      eot_q <= 1'b0;
      if (ack) begin
        cnt_q   <= cnt_q - step;
        lastw_q <= (step == LEN_W'(2));
        bcnt_q  <= (moved >= quota || cnt_q == step) ? 5'd0 : moved;
      end
      if (done_cnt) begin
        en_q <= 1'b0; eot_q <= ceot_q; bcnt_q <= '0;
      end else if (short_hit) begin
        en_q <= 1'b0; eot_q <= 1'b1; bcnt_q <= '0;
      end
      if (reg_wr) begin
        if (reg_sel) len_q <= LEN_W'(reg_wdata);
        else begin
          en_q    <= reg_wdata[0];
          burst_q <= reg_wdata[2:1];
          ep_q    <= reg_wdata[6:3];
          ceot_q  <= reg_wdata[7];
          shen_q  <= reg_wdata[8];
          if (reg_wdata[0] && !en_q) cnt_q <= len_q;
          if (!reg_wdata[0]) bcnt_q <= '0;
        end
      end
      if (bus_reset) begin
        en_q <= 1'b0; bcnt_q <= '0; eot_q <= 1'b0;
      end
    end
  end
endmodule

module dma_burst_ctl_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_reset,
  input logic             reg_wr,
  input logic             dreq,
  input logic             dack,
  input logic             eot,
  input logic             en,
  input logic [LEN_W-1:0] cnt,
  input logic [LEN_W-1:0] len
);
  assert_req_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> (en && cnt != '0));
  assert_eot_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot);
  assert_eot_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> !en);
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> cnt == len);
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && dack && !reg_wr && !bus_reset) |=>
      cnt == $past(cnt) - (($past(cnt) == LEN_W'(1)) ? LEN_W'(1) : LEN_W'(2)));
  assert_busreset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !reg_wr) |=> (!en && !eot && cnt == $past(cnt) && len == $past(len)));
endmodule

bind dma_burst_ctl dma_burst_ctl_chk #(.LEN_W(LEN_W)) chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reg_wr(reg_wr),
  .dreq(dreq), .dack(dack), .eot(eot), .en(en_q), .cnt(cnt_q), .len(len_q)
);

// File: tb/dma_burst_ctl_test.sv
`timescale 1ns/1ps
module dma_burst_ctl_test;
  logic clk = 0, rst_n = 0, bus_reset = 0, reg_wr = 0, reg_sel = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic ep_ready = 0, ep_is_out = 0, short_pkt = 0, dack = 0;
  logic dreq, eot, last_word;
  logic [3:0] ep_index;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dma_burst_ctl uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0; #1;
  endtask

  function automatic logic [15:0] cfg(int run, int b, int ep, int ce, int se);
    return 16'(run | (b << 1) | (ep << 3) | (ce << 7) | (se << 8));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    reg_sel = 0; #1; check("R1 cfg", reg_rdata, 0);
    reg_sel = 1; #1; check("R1 len", reg_rdata, 0);
    check("R1 dreq", dreq, 0); check("R1 eot", eot, 0);

    for (int b = 0; b < 4; b++)
      for (int ce = 0; ce < 2; ce++)
        for (int L = 0; L < 20; L++) begin
          int quota, rem, acks;
          quota = (b == 0) ? 1 : (2 << b);
          wr(1, 16'(L));
          wr(0, cfg(1, b, L % 16, ce, 0) | 16'h0200);
          reg_sel = 0; #1;
          check("R2 cfg", reg_rdata & 16'h01FF, cfg(1, b, L % 16, ce, 0));
          check("R2 ep", ep_index, L % 16);
          reg_sel = 1; #1;
          check("R3 load", reg_rdata, L);
          check("R6 no ready", dreq, 0);
          rem = L; acks = 0;
          while (rem > 0) begin
            int moved;
            moved = 0;
            ep_ready = 1; dack = 1; #1;
            check("R6 start", dreq, 1);
            forever begin
              int st;
              st = (rem == 1) ? 1 : 2;
              rem -= st; moved += st; acks++;
              @(negedge clk); ep_ready = 0; #1;
              check("R3 remain", reg_rdata, rem);
              if (moved >= quota || rem == 0) begin
                check("R5 drop", dreq, 0);
                break;
              end
              check("R5 hold", dreq, 1);
            end
          end
          dack = 0;
          check("R4 acks", acks, (L + 1) / 2);
          @(negedge clk); #1;
          check("R7 eot", eot, ce);
          reg_sel = 0; #1;
          check("R7 run clear", reg_rdata & 1, 0);
          if (L > 0) check("R4 lastword", last_word, (L % 2 == 0) ? 1 : 0);
          @(negedge clk); #1;
          check("R7 pulse", eot, 0);
        end

    // R8 short packet ends an OUT transfer
    wr(1, 16'd20); ep_is_out = 1;
    wr(0, cfg(1, 0, 2, 1, 1));
    short_pkt = 1; @(negedge clk); short_pkt = 0; #1;
    check("R8 eot", eot, 1);
    reg_sel = 0; #1; check("R8 run", reg_rdata & 1, 0);
    reg_sel = 1; #1; check("R8 count", reg_rdata, 20);
    // R8 ignored on IN endpoint
    ep_is_out = 0;
    wr(0, cfg(1, 0, 2, 1, 1));
    short_pkt = 1; @(negedge clk); short_pkt = 0; #1;
    check("R8 in eot", eot, 0);
    reg_sel = 0; #1; check("R8 in run", reg_rdata & 1, 1);
    wr(0, cfg(0, 0, 2, 1, 1));
    // R8 ignored with short mode off
    ep_is_out = 1;
    wr(0, cfg(1, 0, 2, 1, 0));
    short_pkt = 1; @(negedge clk); short_pkt = 0; #1;
    check("R8 off eot", eot, 0);
    reg_sel = 0; #1; check("R8 off run", reg_rdata & 1, 1);

    // R9 abort
    ep_ready = 1; #1;
    check("R9 pre", dreq, 1);
    wr(0, cfg(0, 0, 2, 1, 0));
    check("R9 dreq", dreq, 0);
    check("R9 eot", eot, 0);
    @(negedge clk); #1; check("R9 eot later", eot, 0);
    ep_ready = 0;

    // R10 bus reset
    wr(1, 16'd10);
    wr(0, cfg(1, 2, 5, 1, 0));
    ep_ready = 1; dack = 1;
    @(negedge clk); ep_ready = 0; dack = 0;
    bus_reset = 1; @(negedge clk); bus_reset = 0; #1;
    reg_sel = 0; #1;
    check("R10 cfg", reg_rdata, cfg(0, 2, 5, 1, 0) | 16'h0200);
    reg_sel = 1; #1;
    check("R10 count", reg_rdata, 8);
    check("R10 dreq", dreq, 0);
    ep_ready = 1; #1; check("R10 no req", dreq, 0); ep_ready = 0;
    wr(0, cfg(1, 2, 5, 1, 0));
    reg_sel = 1; #1;
    check("R10 len kept R3", reg_rdata, 10);
    summary();
  end
endmodule